// File: doc/BRIEF.md
# Serial Converter Front End (Device Side)

This block is the digital serial port of a two-channel, 12-bit sampling converter, acting as an SPI slave. All of its logic runs on the serial clock and nothing else. Chip select high holds the frame logic in reset. While chip select is low, the block waits for the first 1 on the data input, which marks the start of a frame. It then captures three command bits and steers the analog input multiplexer from them. It also opens the sample window at the right moment.

After the command, the block drives the conversion word on its serial output. A low null bit comes first, then the word MSB first. If the host asked for it, the word is then repeated LSB first, and zeros follow for as long as the clock keeps running. The converter hands over its result on a parallel input with a valid flag, which is sampled once per frame, at the null bit. Because the block can power up with chip select already low, it stays locked until chip select has been high at least once.

Top module: `adc_serial_fe`

## Requirements
- R1: Rising edges with `cs_n` low and `din` = 0 before the first `din` = 1 are ignored: the first rising edge with `din` = 1 is edge 0 of the frame, and the number of leading zeros does not shift any later timing.
- R2: Rising edges 1, 2 and 3 after the start capture the mode bit (1 = single-ended), the odd bit and the repeat bit. From edge 2 on, `sel_valid` = 1 and `mux_pos` = odd bit. In single-ended mode `mux_neg_gnd` = 1 and `mux_neg` = 0. In differential mode `mux_neg_gnd` = 0 and `mux_neg` = inverse of the odd bit. All four outputs are 0 before edge 2.
- R3: `sample_win` rises on rising edge 2 after the start and falls on the falling edge that follows rising edge 3.
- R4: `dout_oe` stays 0 (output released) until the falling edge after rising edge 3. On that edge `dout_oe` becomes 1 and `dout` drives a 0 null bit.
- R5: The next 12 falling edges drive result bits 11 down to 0.
- R6: With repeat bit 0, every later falling edge drives 0 while `cs_n` stays low.
- R7: With repeat bit 1, the 11 falling edges after bit 0 drive bits 1 up to 11, and every edge after that drives 0.
- R8: If `cs_n` is low when `por_n` is released, no frame starts (outputs stay 0) until `cs_n` has gone high and low again.
- R9: Raising `cs_n` at any time immediately clears `dout_oe`, `sample_win`, `sel_valid` and the mux outputs. The next frame needs a new start bit.
- R10: At the null-bit falling edge the block stores `result` if `result_vld` = 1. Otherwise it keeps the word it stored before, which is 0 after power-on. The stored word is the one shifted out.
- R11: While `por_n` is low, `dout_oe`, `sample_win`, `sel_valid` and the mux outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sclk | input | 1 | Serial clock; the block's only clock |
| cs_n | input | 1 | Chip select, active low; high resets the frame |
| din | input | 1 | Serial command input, sampled on rising edges |
| result | input | 12 | Conversion word from the converter |
| result_vld | input | 1 | `result` holds a fresh word |
| dout | output | 1 | Serial data output, changes on falling edges |
| dout_oe | output | 1 | Output enable for `dout`; 0 means high impedance |
| sample_win | output | 1 | Sample/hold window strobe |
| sel_valid | output | 1 | Mux selection outputs are meaningful |
| mux_pos | output | 1 | Channel index routed to the positive input |
| mux_neg | output | 1 | Channel index routed to the negative input |
| mux_neg_gnd | output | 1 | Negative input tied to ground (single-ended) |

## Verification
A wrong frame position counter shifts the whole output stream. The first sign shows up one falling edge later, as an early or late null bit, or as `sample_win` open for the wrong half cycle. A corrupted command bit shows on the mux outputs from rising edge 2, and for the repeat bit, as bits or zeros in the wrong places after bit 0. A stored word or lockout flag in the wrong state shows only at the next frame: the wrong word is shifted out, or a start bit is accepted while locked.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;

  typedef struct packed {
    logic pos;
    logic neg;
    logic neg_gnd;
  } mux_sel_t;

  // Mode bit 1 = single-ended; the odd bit always names the positive channel.
  function automatic mux_sel_t decode_cfg(logic single, logic odd);
    mux_sel_t s;
    s.pos     = odd;
    s.neg     = single ? 1'b0 : ~odd;
    s.neg_gnd = single;
    return s;
  endfunction

  // Falling-edge slot to result bit index; -1 means drive zero.
  // Slot 3 is the null bit, then MSB-first, then optional LSB-first repeat.
  function automatic int tx_slot_bit(int slot, int res_w, logic lsb_rep);
    int msb_end;
    msb_end = 3 + res_w;
    if (slot > 3 && slot <= msb_end) return msb_end - slot;
    if (lsb_rep && slot > msb_end && slot < msb_end + res_w) return slot - msb_end;
    return -1;
  endfunction

endpackage

// File: rtl/adc_fe_arm.sv
module adc_fe_arm (
  input  logic por_n,
  input  logic cs_n,
  output logic armed
);
  // Set-reset hold: cleared by power-on, set once chip select is seen high.
  always_latch begin
    if (!por_n)    armed <= 1'b0;
    else if (cs_n) armed <= 1'b1;
  end
endmodule

// File: rtl/adc_fe_rx.sv
module adc_fe_rx #(
  parameter int RES_W = 12,
  parameter int CNT_W = 5
) (
  input  logic             sclk,
  input  logic             frame_rst,
  input  logic             din,
  output logic             started,
  output logic [CNT_W-1:0] slot,
  output logic             single_q,
  output logic             odd_q,
  output logic             msbf_q,
  output logic             samp_on
);
  localparam int LAST = 2 * RES_W + 3;

  always_ff @(posedge sclk or posedge frame_rst) begin
    if (frame_rst) begin
      started  <= 1'b0;
      slot     <= '0;
      single_q <= 1'b0;
      odd_q    <= 1'b0;
      msbf_q   <= 1'b0;
      samp_on  <= 1'b0;
    end else if (!started) begin
      if (din) started <= 1'b1;
    end else begin
      if (slot != CNT_W'(LAST)) slot <= slot + CNT_W'(1);
      if (slot == CNT_W'(0)) single_q <= din;
      if (slot == CNT_W'(1)) begin
        odd_q   <= din;
        samp_on <= 1'b1;
      end
      if (slot == CNT_W'(2)) msbf_q <= din;
    end
  end
endmodule

// File: rtl/adc_fe_tx.sv
module adc_fe_tx
  import adc_fe_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CNT_W = 5
) (
  input  logic             sclk,
  input  logic             frame_rst,
  input  logic             por_n,
  input  logic             started,
  input  logic [CNT_W-1:0] slot,
  input  logic             msbf_q,
  input  logic [RES_W-1:0] result,
  input  logic             result_vld,
  output logic             dout,
  output logic             dout_oe,
  output logic             samp_off,
  output logic             null_evt
);
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;

  logic [RES_W-1:0] held;
  int               bit_idx;

  assign null_evt = started && (slot == CNT_W'(3));
  assign bit_idx  = tx_slot_bit(int'(slot), RES_W, msbf_q);

  always_ff @(negedge sclk or negedge por_n) begin
    if (!por_n)                      held <= '0;
    else if (null_evt && result_vld) held <= result;
  end

  always_ff @(negedge sclk or posedge frame_rst) begin
    if (frame_rst) begin
      dout     <= 1'b0;
      dout_oe  <= 1'b0;
      samp_off <= 1'b0;
    end else if (null_evt) begin
      dout     <= 1'b0;
      dout_oe  <= 1'b1;
      samp_off <= 1'b1;
    end else if (dout_oe) begin
      dout <= (bit_idx >= 0) ? held[bit_idx[IDX_W-1:0]] : 1'b0;
    end
  end
endmodule

// File: rtl/adc_serial_fe.sv
module adc_serial_fe
  import adc_fe_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             por_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             din,
  input  logic [RES_W-1:0] result,
  input  logic             result_vld,
  output logic             dout,
  output logic             dout_oe,
  output logic             sample_win,
  output logic             sel_valid,
  output logic             mux_pos,
  output logic             mux_neg,
  output logic             mux_neg_gnd
);
  localparam int CNT_W = $clog2(2 * RES_W + 4);

  logic             armed;
  logic             frame_rst;
  logic             started;
  logic [CNT_W-1:0] slot;
  logic             single_q, odd_q, msbf_q;
  logic             samp_on, samp_off, null_evt;
  mux_sel_t         msel;

  adc_fe_arm u_arm (
    .por_n (por_n),
    .cs_n  (cs_n),
    .armed (armed)
  );

  assign frame_rst = cs_n | ~armed;

  adc_fe_rx #(.RES_W(RES_W), .CNT_W(CNT_W)) u_rx (
    .sclk      (sclk),
    .frame_rst (frame_rst),
    .din       (din),
    .started   (started),
    .slot      (slot),
    .single_q  (single_q),
    .odd_q     (odd_q),
    .msbf_q    (msbf_q),
    .samp_on   (samp_on)
  );

  adc_fe_tx #(.RES_W(RES_W), .CNT_W(CNT_W)) u_tx (
    .sclk       (sclk),
    .frame_rst  (frame_rst),
    .por_n      (por_n),
    .started    (started),
    .slot       (slot),
    .msbf_q     (msbf_q),
    .result     (result),
    .result_vld (result_vld),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .samp_off   (samp_off),
    .null_evt   (null_evt)
  );

  assign sample_win  = samp_on & ~samp_off;
  assign sel_valid   = started && (slot >= CNT_W'(2));
  assign msel        = decode_cfg(single_q, odd_q);
  assign mux_pos     = sel_valid & msel.pos;
  assign mux_neg     = sel_valid & msel.neg;
  assign mux_neg_gnd = sel_valid & msel.neg_gnd;
endmodule

// File: rtl/adc_serial_fe_chk.sv
module adc_serial_fe_chk #(
  parameter int RES_W = 12,
  parameter int CNT_W = 5
) (
  input logic             sclk,
  input logic             por_n,
  input logic             cs_n,
  input logic             frame_rst,
  input logic             armed,
  input logic             started,
  input logic [CNT_W-1:0] slot,
  input logic             msbf_q,
  input logic             dout,
  input logic             dout_oe,
  input logic             sample_win
);
  a_r4_released_early: assert property (@(posedge sclk) disable iff (frame_rst)
    (!started || slot < CNT_W'(3)) |-> !dout_oe);

  a_r4_null_low: assert property (@(posedge sclk) disable iff (frame_rst)
    (started && slot == CNT_W'(3)) |-> (dout_oe && !dout));

  a_r3_window_slot: assert property (@(posedge sclk) disable iff (frame_rst)
    sample_win |-> (started && slot == CNT_W'(2)));

  a_r6_zero_tail: assert property (@(posedge sclk) disable iff (frame_rst)
    (started && !msbf_q && slot >= CNT_W'(RES_W + 4)) |-> !dout);

  a_r8_locked: assert property (@(posedge sclk) disable iff (!por_n)
    !armed |-> !started);

  a_r9_deselected: assert property (@(posedge sclk) disable iff (!por_n)
    cs_n |-> (!dout_oe && !sample_win));
endmodule

bind adc_serial_fe adc_serial_fe_chk #(.RES_W(RES_W), .CNT_W(CNT_W)) i_chk (
  .sclk       (sclk),
  .por_n      (por_n),
  .cs_n       (cs_n),
  .frame_rst  (frame_rst),
  .armed      (armed),
  .started    (started),
  .slot       (slot),
  .msbf_q     (msbf_q),
  .dout       (dout),
  .dout_oe    (dout_oe),
  .sample_win (sample_win)
);

// File: tb/test_adc_serial_fe.sv
`timescale 1ns/1ps
module test_adc_serial_fe;
  logic        por_n, sclk, cs_n, din, result_vld;
  logic [11:0] result;
  logic        dout, dout_oe, sample_win, sel_valid, mux_pos, mux_neg, mux_neg_gnd;

  int tests = 0;
  int fails = 0;
  logic [11:0] model_word = '0;

  typedef struct {
    logic oe, d, sw, sv, mp, mn, mg;
    string dtag;
  } exp_t;
  exp_t exp_q[$];

  adc_serial_fe i_adc_serial_fe (
    .por_n(por_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .result(result), .result_vld(result_vld),
    .dout(dout), .dout_oe(dout_oe), .sample_win(sample_win),
    .sel_valid(sel_valid), .mux_pos(mux_pos), .mux_neg(mux_neg),
    .mux_neg_gnd(mux_neg_gnd)
  );

  initial sclk = 1'b0;
  always #10 sclk = ~sclk;

  task automatic chk(string tag, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_idle(string tag);
    chk(tag, "dout_oe", dout_oe, 1'b0);
    chk(tag, "sample_win", sample_win, 1'b0);
    chk(tag, "sel_valid", sel_valid, 1'b0);
    chk(tag, "mux_pos", mux_pos, 1'b0);
    chk(tag, "mux_neg", mux_neg, 1'b0);
    chk(tag, "mux_neg_gnd", mux_neg_gnd, 1'b0);
  endtask

  // Monitor: one expected item per falling edge, compared just after it.
  initial begin
    forever begin
      @(negedge sclk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R4", "dout_oe", dout_oe, e.oe);
        chk(e.dtag, "dout", dout, e.d);
        chk("R3", "sample_win", sample_win, e.sw);
        chk("R2", "sel_valid", sel_valid, e.sv);
        chk("R2", "mux_pos", mux_pos, e.mp);
        chk("R2", "mux_neg", mux_neg, e.mn);
        chk("R2", "mux_neg_gnd", mux_neg_gnd, e.mg);
      end
    end
  end

  task automatic next_fall();
    @(negedge sclk);
    #3;
  endtask

  // Driver: runs one frame; nclk counts edges from the start bit on.
  task automatic frame(int lead, bit sgl, bit odd, bit rep, logic [11:0] res,
                       bit vld, int nclk, string word_tag);
    logic stream[$];
    cs_n = 1'b0;
    result = res;
    result_vld = vld;
    if (vld) model_word = res;
    stream.push_back(1'b0);
    for (int i = 11; i >= 0; i--) stream.push_back(model_word[i]);
    if (rep) for (int i = 1; i <= 11; i++) stream.push_back(model_word[i]);
    for (int i = 0; i < lead + nclk; i++) begin
      exp_t e;
      int k;
      k = i - lead;
      din = (k == 0) ? 1'b1 : (k == 1) ? sgl : (k == 2) ? odd : (k == 3) ? rep : 1'b0;
      e.oe = (k >= 3);
      e.d  = (k >= 3 && (k - 3) < stream.size()) ? stream[k-3] : 1'b0;
      e.sw = (k == 2);
      e.sv = (k >= 2);
      e.mp = e.sv & odd;
      e.mn = e.sv & ~sgl & ~odd;
      e.mg = e.sv & sgl;
      if (k < 0) e.dtag = "R1";
      else if (k <= 3) e.dtag = "R4";
      else if (word_tag != "") e.dtag = word_tag;
      else if (k <= 15) e.dtag = "R5";
      else if (rep) e.dtag = "R7";
      else e.dtag = "R6";
      exp_q.push_back(e);
      next_fall();
    end
    cs_n = 1'b1;
    din = 1'b0;
    #1;
    chk_idle("R9");
    next_fall();
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    por_n = 1'b0; cs_n = 1'b0; din = 1'b0; result = '0; result_vld = 1'b0;
    next_fall();
    chk_idle("R11");
    por_n = 1'b1;
    // Locked: chip select never went high since power-on.
    for (int i = 0; i < 10; i++) begin
      exp_t e;
      din = (i % 3 != 2);
      e = '{oe: 1'b0, d: 1'b0, sw: 1'b0, sv: 1'b0, mp: 1'b0, mn: 1'b0, mg: 1'b0, dtag: "R8"};
      exp_q.push_back(e);
      next_fall();
    end
    cs_n = 1'b1; din = 1'b0;
    next_fall();
    // Nothing latched yet: word is zero (R10).
    frame(0, 1'b1, 1'b0, 1'b1, 12'hABC, 1'b0, 28, "R10");
    frame(0, 1'b1, 1'b0, 1'b0, 12'hA5C, 1'b1, 20, "");
    frame(5, 1'b1, 1'b1, 1'b1, 12'h3E7, 1'b1, 32, "");
    // Stale word reused when valid is low (R10).
    frame(2, 1'b0, 1'b0, 1'b1, 12'h800, 1'b0, 30, "R10");
    frame(1, 1'b0, 1'b1, 1'b0, 12'hFFF, 1'b1, 18, "");
    // Abort mid-word, then restart with leading zeros (R9).
    frame(0, 1'b0, 1'b0, 1'b1, 12'h5A5, 1'b1, 9, "");
    frame(3, 1'b1, 1'b1, 1'b1, 12'h001, 1'b1, 29, "");
    frame(0, 1'b0, 1'b1, 1'b1, 12'h800, 1'b1, 27, "");
    next_fall();
    next_fall();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule